// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block supervises link integrity for one twisted-pair port of a multiport repeater. It watches two receive events from the port's decoder: a qualified link test pulse and a data-packet indication. From them it keeps the port in a link-pass or link-fail state. While the port is in link fail, the repeater must neither forward traffic from the port nor send traffic to it. The `port_enable_o` output carries that decision to the repeat core.

On the transmit side, the block asks the line driver for a link test pulse whenever the port's transmitter has been quiet for too long. These requests are made in every port state.

Both windows are measured in ticks of a shared timebase (`tick_i`). Their lengths are parameters, so one design serves the nominal millisecond windows and shortened windows for test. Per-port receive checking can be switched off for legacy cabling that sends no pulses.

Top module: `tp_link_monitor`

## Requirements
- R1: During and right after reset, link_fail_o is 1, port_enable_o is 0 and tx_link_pulse_req_o is 0.
- R2: With tx_active_i low, tx_link_pulse_req_o goes high for exactly one cycle, in the cycle after the TX_IDLE_TICKS-th tick since the last restart. The idle count then restarts and the requests repeat.
- R3: A cycle with tx_active_i high clears the idle count, and tx_link_pulse_req_o is 0 in the following cycle.
- R4: Requests for link test pulses are made regardless of link_fail_o and link_test_en_i.
- R5: While link_test_en_i is 1 and the port is in link pass, link_fail_o becomes 1 in the cycle after the LINK_LOSS_TICKS-th tick with no receive event.
- R6: Any cycle with rx_link_pulse_i or rx_packet_i high clears the link-loss count and blocks a fail transition in that cycle.
- R7: port_enable_o is always the inverse of link_fail_o.
- R8: In link fail with checking enabled, a cycle with rx_packet_i high makes link_fail_o 0 in the next cycle.
- R9: In link fail, the RECOVER_PULSES-th consecutive link pulse (default 4) makes link_fail_o 0 in the next cycle. Fewer pulses leave it at 1.
- R10: In link fail, if the link-loss window expires between pulses, the pulse count restarts from zero.
- R11: With link_test_en_i at 0, the port never enters link fail. A port already in link fail returns to link pass in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle per time unit |
| rx_link_pulse_i | input | 1 | One-cycle strobe per qualified received link pulse |
| rx_packet_i | input | 1 | One-cycle strobe per received data packet |
| tx_active_i | input | 1 | Port transmitter is sending |
| link_test_en_i | input | 1 | Enable link-test receive checking |
| link_fail_o | output | 1 | Port is in link fail |
| port_enable_o | output | 1 | Repeater may transmit to and receive from the port |
| tx_link_pulse_req_o | output | 1 | One-cycle request to send a link test pulse |

## Verification
The assertions take all inputs as synchronous to clk_i and each receive strobe as lasting one cycle per event. The timebase tick may arrive in any cycle, including back to back. The bench drives every input once per cycle, away from the clock edge. Each receive event is a single-cycle pulse, and ticks, receive events, transmit activity and enable changes are drawn with fixed probabilities, so every combination arises, including events that fall on the same cycle as a tick.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;
  typedef enum logic {
    LINK_PASS = 1'b0,
    LINK_FAIL = 1'b1
  } link_state_e;
endpackage

// File: rtl/tp_tick_timer.sv
module tp_tick_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = tick_i & ~clear_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || expire_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tp_link_fsm.sv
module tp_link_fsm
  import tp_link_pkg::*;
#(
  parameter int unsigned RECOVER_PULSES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_en_i,
  input  logic rx_pulse_i,
  input  logic rx_packet_i,
  input  logic loss_expire_i,
  output logic link_fail_o
);
  localparam int unsigned PW = (RECOVER_PULSES > 1) ? $clog2(RECOVER_PULSES) : 1;
  localparam logic [PW-1:0] PLAST = PW'(RECOVER_PULSES - 1);

  link_state_e   state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      LINK_PASS: begin
        pcnt_d = '0;
        if (test_en_i && loss_expire_i) state_d = LINK_FAIL;
      end
      LINK_FAIL: begin
        if (!test_en_i || rx_packet_i) begin
          state_d = LINK_PASS;
          pcnt_d  = '0;
        end else if (rx_pulse_i) begin
          if (pcnt_q == PLAST) begin
            state_d = LINK_PASS;
            pcnt_d  = '0;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end else if (loss_expire_i) begin
          pcnt_d = '0;  // run of pulses broken
        end
      end
      default: state_d = LINK_FAIL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINK_FAIL;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign link_fail_o = (state_q == LINK_FAIL);
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor #(
  parameter int unsigned TX_IDLE_TICKS   = 16,
  parameter int unsigned LINK_LOSS_TICKS = 100,
  parameter int unsigned RECOVER_PULSES  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_link_pulse_i,
  input  logic rx_packet_i,
  input  logic tx_active_i,
  input  logic link_test_en_i,
  output logic link_fail_o,
  output logic port_enable_o,
  output logic tx_link_pulse_req_o
);
  logic tx_expire, loss_expire, rx_event, req_q;

  assign rx_event = rx_link_pulse_i | rx_packet_i;

  tp_tick_timer #(.LIMIT(TX_IDLE_TICKS)) u_tx_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tx_active_i),
    .tick_i  (tick_i),
    .expire_o(tx_expire)
  );

  tp_tick_timer #(.LIMIT(LINK_LOSS_TICKS)) u_link_loss (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rx_event),
    .tick_i  (tick_i),
    .expire_o(loss_expire)
  );

  tp_link_fsm #(.RECOVER_PULSES(RECOVER_PULSES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .test_en_i    (link_test_en_i),
    .rx_pulse_i   (rx_link_pulse_i),
    .rx_packet_i  (rx_packet_i),
    .loss_expire_i(loss_expire),
    .link_fail_o  (link_fail_o)
  );

  // pulse requests ignore link state by design
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= tx_expire;
  end

  assign tx_link_pulse_req_o = req_q;
  assign port_enable_o       = ~link_fail_o;
endmodule

// File: rtl/tp_link_monitor_chk.sv
module tp_link_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic rx_link_pulse_i,
  input logic rx_packet_i,
  input logic tx_active_i,
  input logic link_test_en_i,
  input logic link_fail_o,
  input logic port_enable_o,
  input logic tx_link_pulse_req_o
);
  // R7
  enable_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_enable_o != link_fail_o);

  // R5
  fail_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_fail_o) |-> $past(link_test_en_i) && $past(tick_i));

  // R6
  rx_event_blocks_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_link_pulse_i || rx_packet_i) |=> !$rose(link_fail_o));

  // R8
  packet_recovers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_test_en_i && rx_packet_i) |=> !link_fail_o);

  // R11
  disabled_no_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_test_en_i |=> !link_fail_o);

  // R3
  tx_active_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> !tx_link_pulse_req_o);

  // R2
  req_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_link_pulse_req_o |-> $past(tick_i));
endmodule

bind tp_link_monitor tp_link_monitor_chk u_chk (.*);

// File: tb/tp_link_monitor_test.sv
module tp_link_monitor_test;
  localparam int TXI  = 4;
  localparam int LOSS = 10;
  localparam int NREC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, pulse = 0, pkt = 0, txa = 0, en = 1;
  logic fail_o, pe_o, req_o;
  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int  m_tc = 0, m_lc = 0, m_pc = 0;
  bit  m_fail = 1, m_req = 0;

  always #5 clk = ~clk;

  tp_link_monitor #(.TX_IDLE_TICKS(TXI), .LINK_LOSS_TICKS(LOSS), .RECOVER_PULSES(NREC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_link_pulse_i(pulse),
    .rx_packet_i(pkt), .tx_active_i(txa), .link_test_en_i(en),
    .link_fail_o(fail_o), .port_enable_o(pe_o), .tx_link_pulse_req_o(req_o));

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step();
    bit evt, exp_l;
    // transmit idle timer
    if (txa) begin m_tc = 0; m_req = 0; end
    else if (tick && m_tc == TXI-1) begin m_tc = 0; m_req = 1; end
    else begin if (tick) m_tc++; m_req = 0; end
    // link loss timer
    evt   = pulse | pkt;
    exp_l = tick && !evt && m_lc == LOSS-1;
    if (evt || exp_l) m_lc = 0; else if (tick) m_lc++;
    // link state
    if (!m_fail) begin
      m_pc = 0;
      if (en && exp_l) m_fail = 1;
    end else if (!en || pkt) begin m_fail = 0; m_pc = 0; end
    else if (pulse) begin
      if (m_pc == NREC-1) begin m_fail = 0; m_pc = 0; end else m_pc++;
    end else if (exp_l) m_pc = 0;
  endfunction

  task automatic step(bit t, bit p, bit k, bit a, bit e, string tag_fail, string tag_req);
    @(negedge clk);
    tick = t; pulse = p; pkt = k; txa = a; en = e;
    model_step();
    @(posedge clk); #1;
    check(tag_fail, fail_o, m_fail);
    check("R7", pe_o, ~m_fail);
    check(tag_req, req_o, m_req);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    #12;
    // R1 reset state
    check("R1", fail_o, 1'b1);
    check("R1", pe_o, 1'b0);
    check("R1", req_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(0,0,0,0,1,"R1","R1");
    // R8: packet recovers at once
    step(0,0,1,0,1,"R8","R2");
    // R5: loss window with idle receive; tx idle gives requests (R2)
    for (int i = 0; i < LOSS; i++) step(1,0,0,0,1,"R5","R2");
    // R9 and R10: three pulses, window expires, three more stay in fail
    for (int i = 0; i < NREC-1; i++) step(0,1,0,0,1,"R9","R4");
    for (int i = 0; i < LOSS; i++)   step(1,0,0,1,1,"R10","R3");
    for (int i = 0; i < NREC-1; i++) step(1,1,0,0,1,"R10","R4");
    step(0,1,0,0,1,"R9","R4");
    // R6: events every few ticks keep link up
    for (int i = 0; i < 4*LOSS; i++) step(1, (i%(LOSS-1))==0, 0, 0, 1, "R6", "R2");
    // R11: checking disabled never fails; disabling in fail recovers
    for (int i = 0; i < 3*LOSS; i++) step(1,0,0,0,0,"R11","R4");
    for (int i = 0; i < LOSS; i++)   step(1,0,0,0,1,"R5","R2");
    step(0,0,0,0,0,"R11","R4");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit e = ($urandom%50) != 0;
      step(($urandom%3)==0, ($urandom%18)==0, ($urandom%70)==0,
           ($urandom%8)==0, e, e ? "R5/R6/R9" : "R11", "R2/R3");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule